// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block is a small synchronous static RAM with a wide data word split into eight byte lanes and a built-in two-bit burst sequencer. The address, write data and every control input except output enable and the burst-order select are captured on the rising clock edge. An access is started by one of two address strobes: a processor-side strobe or a controller-side strobe. An advance input then walks the remaining three words of an aligned group of four, in linear or interleaved order. The order is chosen by a static, unregistered mode pin.

Writes are self-timed. The captured data is written into the array on the clock edge that follows the capture, with no external write pulse. The write qualifiers are a per-lane enable set, a common write enable and a global write input. A build parameter selects the read path. In pipelined mode the read data passes through an output register. In flow-through mode it comes straight from the array. The output has a separate valid flag, which models the high-impedance state.

Top module: `bsram_core`

## Requirements
- R1: While reset is asserted, and after its release until a strobe arrives, no burst is active and `dout_vld_o` is 0. An advance input alone does not start an access.
- R2: A strobe captured on an edge loads `addr_i` as the burst start address and clears the burst count. The access in the following cycle is at exactly that address.
- R3: A captured advance moves the burst count forward by one, modulo 4. A cycle with no strobe, advance or deselect repeats the access at the current address. The upper address bits (all but the two lowest) never change during a burst.
- R4: With `order_ilv_i`=0 the two low address bits are the start bits plus the count, modulo 4. With `order_ilv_i`=1 they are the start bits XOR the count. The pin is not registered: a change moves the current address without a clock edge.
- R5: The processor-side strobe wins when both strobes are captured together. Its first access is always a read, whatever the write inputs are.
- R6: Lane j is data bits [8j+7:8j], with lane a being lane 0. It is written when its bit of `lane_en_i` and `wr_en_i` are captured high together. The other lanes keep their contents.
- R7: `wr_all_i` writes all eight lanes, whatever the other write inputs are. All lane enables together with `wr_en_i` also write every lane.
- R8: Lane enables captured without `wr_en_i` or `wr_all_i` write nothing, and that access is a read.
- R9: With PIPELINED=0, read data and valid appear in the cycle after the capturing edge. With PIPELINED=1 they appear one cycle later, held in an output register.
- R10: `dout_vld_o` is 1 only while `oe_i` is high and the access being shown is a read. An access that writes any lane shows no output. `oe_i` acts without a clock edge.
- R11: A captured deselect ends the burst after one cycle, so the next cycle has no access. Advance inputs while no burst is active are ignored.
- R12: Data written by one access is returned by a read access in the very next cycle, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all captures on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Burst start address |
| start_cpu_i | input | 1 | Processor-side address strobe (read first) |
| start_ctl_i | input | 1 | Controller-side address strobe |
| adv_i | input | 1 | Advance the burst count |
| desel_i | input | 1 | Deselect; ends the current burst |
| order_ilv_i | input | 1 | Burst order: 0 linear, 1 interleaved (unregistered) |
| wr_en_i | input | 1 | Common write enable for lane writes |
| wr_all_i | input | 1 | Global write of all lanes |
| lane_en_i | input | LANES | Per-lane write enables |
| din_i | input | LANES*LANE_W | Write data |
| oe_i | input | 1 | Output enable (unregistered) |
| dout_o | output | LANES*LANE_W | Read data |
| dout_vld_o | output | 1 | Output driven (low models high impedance) |

## Verification
The bench builds two copies of the block with the default sizes (64 words of eight 8-bit lanes): `dut_i` with PIPELINED=1 and `dut_ft_i` with PIPELINED=0. Both run the same stimulus. This puts both read-path variants and their one-cycle latency difference within reach in a single run. It also exposes the interaction between the unregistered order pin and the late write and the output capture. With 64 words, an address with non-zero upper bits shows that a burst keeps its aligned group of four.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

   // Low two address bits of the current beat of a burst.
   function automatic logic [1:0] burst_low(input logic [1:0] start,
                                            input logic [1:0] count,
                                            input logic       ilv);
      logic [1:0] r;
      if (ilv) r = start ^ count;
      else     r = start + count;
      return r;
   endfunction

endpackage

// File: rtl/bsram_wqual.sv
module bsram_wqual #(
   parameter int LANES = 8
) (
   input  logic             wr_en_i,
   input  logic             wr_all_i,
   input  logic [LANES-1:0] lane_en_i,
   output logic [LANES-1:0] mask_o
);
   generate
      if (LANES < 1) begin : g_bad
         $error("bsram_wqual: LANES must be at least 1");
      end
   endgenerate

   // Global write wins; otherwise a lane needs its own enable and the common enable.
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign mask_o[j] = wr_all_i | (wr_en_i & lane_en_i[j]);
   end
endmodule

// File: rtl/bsram_seq.sv
module bsram_seq
   import bsram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              start_cpu_i,
   input  logic              start_ctl_i,
   input  logic              adv_i,
   input  logic              desel_i,
   input  logic              ilv_i,
   input  logic [LANES-1:0]  wmask_i,
   output logic              act_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [LANES-1:0]  wmask_o
);
   localparam int HI_W = ADDR_W - 2;

   generate
      if (ADDR_W < 3) begin : g_bad
         $error("bsram_seq: ADDR_W must be at least 3");
      end
   endgenerate

   logic              act_q;
   logic [ADDR_W-1:0] base_q;
   logic [1:0]        cnt_q;
   logic [LANES-1:0]  wm_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q  <= 1'b0;
         base_q <= '0;
         cnt_q  <= '0;
         wm_q   <= '0;
      end else if (desel_i) begin
         act_q <= 1'b0;
         wm_q  <= '0;
      end else if (start_cpu_i) begin
         act_q  <= 1'b1;
         base_q <= addr_i;
         cnt_q  <= '0;
         wm_q   <= '0;
      end else if (start_ctl_i) begin
         act_q  <= 1'b1;
         base_q <= addr_i;
         cnt_q  <= '0;
         wm_q   <= wmask_i;
      end else if (act_q) begin
         if (adv_i) cnt_q <= cnt_q + 2'd1;
         wm_q <= wmask_i;
      end else begin
         wm_q <= '0;
      end
   end

   logic [HI_W-1:0] hi;
   assign hi      = base_q[ADDR_W-1:2];
   assign addr_o  = {hi, burst_low(base_q[1:0], cnt_q, ilv_i)};
   assign act_o   = act_q;
   assign wmask_o = wm_q;

   a_r2_start_load : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((start_cpu_i || start_ctl_i) && !desel_i) |=>
         (act_q && cnt_q == 2'd0 && base_q == $past(addr_i)));

   a_r3_step : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_q && adv_i && !start_cpu_i && !start_ctl_i && !desel_i) |=>
         (cnt_q == $past(cnt_q) + 2'd1 && $stable(base_q)));

   a_r3_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_q && !adv_i && !start_cpu_i && !start_ctl_i && !desel_i) |=>
         ($stable(cnt_q) && $stable(base_q)));

   a_r5_cpu_read : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_cpu_i && !desel_i) |=> (wm_q == '0));

   a_r11_desel : assert property (@(posedge clk_i) disable iff (!rst_ni)
      desel_i |=> !act_q);
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 8,
   parameter int LANE_W = 8
) (
   input  logic                    clk_i,
   input  logic [LANES-1:0]        we_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [LANES*LANE_W-1:0] wdata_i,
   output logic [LANES*LANE_W-1:0] rdata_o
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (DEPTH * LANES * LANE_W > 65536) begin : g_bad
         $error("bsram_array: array too large for a register memory");
      end
   endgenerate

   // One independent storage column per lane.
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk_i) begin
         if (we_i[j]) mem[addr_i] <= wdata_i[j*LANE_W +: LANE_W];
      end

      assign rdata_o[j*LANE_W +: LANE_W] = mem[addr_i];
   end
endmodule

// File: rtl/bsram_rdpath.sv
module bsram_rdpath #(
   parameter int DATA_W    = 64,
   parameter bit PIPELINED = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              oe_i,
   output logic [DATA_W-1:0] dout_o,
   output logic              vld_o
);
   if (PIPELINED) begin : g_pipe
      logic [DATA_W-1:0] dq;
      logic              rq;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            dq <= '0;
            rq <= 1'b0;
         end else begin
            dq <= data_i;
            rq <= rd_i;
         end
      end

      assign dout_o = dq;
      assign vld_o  = rq & oe_i;

      a_r10_no_out_after_write : assert property (@(posedge clk_i) disable iff (!rst_ni)
         !rd_i |=> !vld_o);

      a_r9_pipe_latency : assert property (@(posedge clk_i) disable iff (!rst_ni)
         rd_i |=> (dout_o == $past(data_i)));
   end else begin : g_flow
      assign dout_o = data_i;
      assign vld_o  = rd_i & oe_i;
   end
endmodule

// File: rtl/bsram_core.sv
module bsram_core #(
   parameter int ADDR_W    = 6,
   parameter int LANES     = 8,
   parameter int LANE_W    = 8,
   parameter bit PIPELINED = 1'b1
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic                    start_cpu_i,
   input  logic                    start_ctl_i,
   input  logic                    adv_i,
   input  logic                    desel_i,
   input  logic                    order_ilv_i,
   input  logic                    wr_en_i,
   input  logic                    wr_all_i,
   input  logic [LANES-1:0]        lane_en_i,
   input  logic [LANES*LANE_W-1:0] din_i,
   input  logic                    oe_i,
   output logic [LANES*LANE_W-1:0] dout_o,
   output logic                    dout_vld_o
);
   localparam int DATA_W = LANES * LANE_W;

   generate
      if (LANE_W < 1) begin : g_bad
         $error("bsram_core: LANE_W must be at least 1");
      end
   endgenerate

   logic [LANES-1:0]  wmask_in, wmask_q, we;
   logic              act;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] din_q, rdata;
   logic              rd;

   bsram_wqual #(.LANES(LANES)) u_wqual (
      .wr_en_i  (wr_en_i),
      .wr_all_i (wr_all_i),
      .lane_en_i(lane_en_i),
      .mask_o   (wmask_in)
   );

   bsram_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .addr_i     (addr_i),
      .start_cpu_i(start_cpu_i),
      .start_ctl_i(start_ctl_i),
      .adv_i      (adv_i),
      .desel_i    (desel_i),
      .ilv_i      (order_ilv_i),
      .wmask_i    (wmask_in),
      .act_o      (act),
      .addr_o     (cur_addr),
      .wmask_o    (wmask_q)
   );

   // Captured write data, committed on the next edge (self-timed late write).
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) din_q <= '0;
      else         din_q <= din_i;
   end

   assign we = act ? wmask_q : '0;
   assign rd = act & (wmask_q == '0);

   bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk_i  (clk_i),
      .we_i   (we),
      .addr_i (cur_addr),
      .wdata_i(din_q),
      .rdata_o(rdata)
   );

   bsram_rdpath #(.DATA_W(DATA_W), .PIPELINED(PIPELINED)) u_rd (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .rd_i  (rd),
      .data_i(rdata),
      .oe_i  (oe_i),
      .dout_o(dout_o),
      .vld_o (dout_vld_o)
   );

   a_r1_idle_no_write : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!act && !start_cpu_i && !start_ctl_i) |=> (we == '0));

   a_r7_global_all_lanes : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_ctl_i && !start_cpu_i && !desel_i && wr_all_i) |=> ($countones(we) == LANES));
endmodule

// File: tb/bsram_core_tb.sv
module bsram_core_tb_top;
   localparam int AW = 6;
   localparam int NL = 8;
   localparam int DW = 64;
   localparam int NV = 27;

   // {req[3:0], kind[2:0], wen, wall, ilv, oe, lanes[7:0], addr[5:0], seed[7:0]}
   // kind: 0 idle, 1 cpu strobe, 2 ctl strobe, 3 advance, 4 deselect, 5 both strobes
   typedef logic [32:0] vec_t;

   function automatic vec_t mk(input int req, input int kind, input bit wen, input bit wall,
                               input bit ilv, input bit oe, input logic [7:0] lanes,
                               input logic [5:0] addr, input logic [7:0] seed);
      return {4'(req), 3'(kind), wen, wall, ilv, oe, lanes, addr, seed};
   endfunction

   localparam vec_t VEC [NV] = '{
      mk( 7, 2, 0, 1, 0, 1, 8'h00,  8, 8'h10), // R7 ctl start, global write @8
      mk( 7, 3, 1, 0, 0, 1, 8'hFF,  0, 8'h20), // R7 all lanes + wr_en @9
      mk( 3, 3, 0, 1, 0, 1, 8'h00,  0, 8'h30), // R3 @10
      mk( 6, 3, 1, 0, 0, 1, 8'hFF,  0, 8'h40), // R6 @11
      mk( 2, 1, 0, 0, 0, 1, 8'h00,  8, 8'h00), // R2 read @8
      mk( 3, 3, 0, 0, 0, 1, 8'h00,  0, 8'h00), // R3 @9
      mk( 9, 3, 0, 0, 0, 1, 8'h00,  0, 8'h00), // R9 @10
      mk( 3, 3, 0, 0, 0, 1, 8'h00,  0, 8'h00), // R3 @11
      mk( 3, 3, 0, 0, 0, 1, 8'h00,  0, 8'h00), // R3 wrap @8
      mk( 4, 1, 0, 0, 1, 1, 8'h00,  9, 8'h00), // R4 ilv @9
      mk( 4, 3, 0, 0, 1, 1, 8'h00,  0, 8'h00), // R4 @8
      mk( 4, 3, 0, 0, 1, 1, 8'h00,  0, 8'h00), // R4 @11
      mk( 4, 3, 0, 0, 1, 1, 8'h00,  0, 8'h00), // R4 @10
      mk( 6, 2, 1, 0, 0, 1, 8'h0F,  8, 8'h50), // R6 lanes a-d @8
      mk(12, 0, 0, 0, 0, 1, 8'h00,  0, 8'h00), // R12 hold read @8
      mk( 8, 2, 0, 0, 0, 1, 8'hFF,  9, 8'h55), // R8 lane enables, no wr_en
      mk( 5, 1, 0, 1, 0, 1, 8'h00, 11, 8'h60), // R5 cpu start with wr_all: read
      mk( 7, 3, 0, 1, 0, 1, 8'h00,  0, 8'h70), // R7 write @8 (wrap)
      mk(10, 0, 0, 0, 0, 0, 8'h00,  0, 8'h00), // R10 oe low
      mk(12, 0, 0, 0, 0, 1, 8'h00,  0, 8'h00), // R12 read @8
      mk(11, 4, 0, 0, 0, 1, 8'h00,  0, 8'h00), // R11 deselect
      mk(11, 3, 0, 0, 0, 1, 8'h00,  0, 8'h00), // R11 advance while idle
      mk( 7, 2, 1, 0, 0, 1, 8'hFF, 40, 8'h80), // R7 @40
      mk( 5, 5, 0, 1, 0, 1, 8'h00, 40, 8'h90), // R5 both strobes: read @40
      mk( 9, 0, 0, 0, 0, 1, 8'h00,  0, 8'h00), // R9 hold @40
      mk(10, 2, 1, 0, 0, 1, 8'h81, 10, 8'h99), // R10 partial write, no output
      mk( 6, 0, 0, 0, 0, 1, 8'h00,  0, 8'h00)  // R6 read merged @10
   };

   function automatic string req_name(input int r);
      case (r)
         1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
         5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
         9: return "R9";  10: return "R10"; 11: return "R11"; 12: return "R12";
         default: return "R?";
      endcase
   endfunction

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          s_cpu = 0, s_ctl = 0, adv = 0, desel = 0, ilv = 0;
   logic          wen = 0, wall = 0, oe = 0;
   logic [NL-1:0] lanes = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout_p, dout_f;
   logic          vld_p, vld_f;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   bsram_core #(.ADDR_W(AW), .LANES(NL), .LANE_W(8), .PIPELINED(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .start_cpu_i(s_cpu), .start_ctl_i(s_ctl),
      .adv_i(adv), .desel_i(desel), .order_ilv_i(ilv), .wr_en_i(wen), .wr_all_i(wall),
      .lane_en_i(lanes), .din_i(din), .oe_i(oe), .dout_o(dout_p), .dout_vld_o(vld_p));

   bsram_core #(.ADDR_W(AW), .LANES(NL), .LANE_W(8), .PIPELINED(1'b0)) dut_ft_i (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .start_cpu_i(s_cpu), .start_ctl_i(s_ctl),
      .adv_i(adv), .desel_i(desel), .order_ilv_i(ilv), .wr_en_i(wen), .wr_all_i(wall),
      .lane_en_i(lanes), .din_i(din), .oe_i(oe), .dout_o(dout_f), .dout_vld_o(vld_f));

   // Reference state, written from the requirements.
   logic [DW-1:0] mmem [1 << AW];
   logic          m_act = 0;
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_cnt = '0;
   logic [NL-1:0] m_wm = '0;
   logic [DW-1:0] m_din = '0;
   logic          e_vld_p = 0, e_vld_f = 0;
   logic [DW-1:0] e_dat_p = '0, e_dat_f = '0;

   function automatic logic [DW-1:0] mkdata(input logic [7:0] seed);
      logic [DW-1:0] d;
      for (int j = 0; j < NL; j++) d[j*8 +: 8] = seed + 8'(j);
      return d;
   endfunction

   function automatic logic [AW-1:0] cur_of(input logic [AW-1:0] b, input logic [1:0] c,
                                            input logic o);
      return {b[AW-1:2], (o ? (b[1:0] ^ c) : (b[1:0] + c))};
   endfunction

   task automatic check(input string req, input string what, input logic [DW:0] act_v,
                        input logic [DW:0] exp_v);
      n_chk++;
      if (act_v !== exp_v) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act_v, exp_v);
      end
   endtask

   // Model of one rising edge, using the inputs present at that edge.
   task automatic model_edge();
      logic [AW-1:0] oc;
      logic [NL-1:0] wm_in;
      logic          p_rd;
      logic [DW-1:0] p_dat;
      oc    = cur_of(m_base, m_cnt, ilv);
      p_rd  = m_act && (m_wm == '0);
      p_dat = mmem[oc];
      if (m_act)
         for (int j = 0; j < NL; j++)
            if (m_wm[j]) mmem[oc][j*8 +: 8] = m_din[j*8 +: 8];
      wm_in = wall ? '1 : (wen ? lanes : '0);
      if (desel) begin
         m_act = 0; m_wm = '0;
      end else if (s_cpu) begin
         m_act = 1; m_base = addr; m_cnt = 0; m_wm = '0;
      end else if (s_ctl) begin
         m_act = 1; m_base = addr; m_cnt = 0; m_wm = wm_in;
      end else if (m_act) begin
         if (adv) m_cnt = m_cnt + 2'd1;
         m_wm = wm_in;
      end else begin
         m_wm = '0;
      end
      m_din   = din;
      e_vld_p = p_rd && oe;
      e_dat_p = p_dat;
      e_vld_f = m_act && (m_wm == '0) && oe;
      e_dat_f = mmem[cur_of(m_base, m_cnt, ilv)];
   endtask

   task automatic check_outs(input string req);
      check(req, "pipelined valid", {{DW{1'b0}}, vld_p}, {{DW{1'b0}}, e_vld_p});
      check(req, "flow valid", {{DW{1'b0}}, vld_f}, {{DW{1'b0}}, e_vld_f});
      if (e_vld_p) check(req, "pipelined data", {1'b0, dout_p}, {1'b0, e_dat_p});
      if (e_vld_f) check(req, "flow data", {1'b0, dout_f}, {1'b0, e_dat_f});
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      s_cpu = (v[28:26] == 3'd1) || (v[28:26] == 3'd5);
      s_ctl = (v[28:26] == 3'd2) || (v[28:26] == 3'd5);
      adv   = (v[28:26] == 3'd3);
      desel = (v[28:26] == 3'd4);
      wen   = v[25];
      wall  = v[24];
      ilv   = v[23];
      oe    = v[22];
      lanes = v[21:14];
      addr  = v[13:8];
      din   = mkdata(v[7:0]);
      @(posedge clk);
      model_edge();
      #2;
      check_outs(req_name(int'(v[32:29])));
   endtask

   initial begin
      #(200000 * 10);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < (1 << AW); i++) mmem[i] = '0;
      // R1: reset state
      repeat (3) @(posedge clk);
      #2;
      check("R1", "pipelined valid in reset", {{DW{1'b0}}, vld_p}, '0);
      check("R1", "flow valid in reset", {{DW{1'b0}}, vld_f}, '0);
      @(negedge clk);
      rst_n = 1'b1;
      oe    = 1'b1;
      adv   = 1'b1;  // R1: advance without a strobe starts nothing
      @(posedge clk);
      model_edge();
      #2;
      check_outs("R1");

      for (int i = 0; i < NV; i++) apply(VEC[i]);

      // R4: order pin acts without a clock edge. Burst from 9, one advance.
      apply(mk(4, 1, 0, 0, 0, 1, 8'h00, 9, 8'h00));
      apply(mk(4, 3, 0, 0, 0, 1, 8'h00, 0, 8'h00));
      apply(mk(4, 0, 0, 0, 0, 1, 8'h00, 0, 8'h00));
      check("R4", "flow data linear beat", {1'b0, dout_f}, {1'b0, mmem[10]});
      ilv = 1'b1;
      #1;
      check("R4", "flow data after order change", {1'b0, dout_f}, {1'b0, mmem[8]});
      // R10: output enable acts without a clock edge
      oe = 1'b0;
      #1;
      check("R10", "flow valid with oe low", {{DW{1'b0}}, vld_f}, '0);
      check("R10", "pipelined valid with oe low", {{DW{1'b0}}, vld_p}, '0);

      // R1: reset in the middle of a burst
      @(negedge clk);
      ilv = 1'b0;
      oe  = 1'b1;
      rst_n = 1'b0;
      #2;
      check("R1", "pipelined valid after mid-burst reset", {{DW{1'b0}}, vld_p}, '0);
      check("R1", "flow valid after mid-burst reset", {{DW{1'b0}}, vld_f}, '0);
      m_act = 0; m_wm = '0; m_cnt = '0; m_base = '0;
      @(negedge clk);
      rst_n = 1'b1;
      apply(mk(11, 3, 0, 0, 0, 1, 8'h00, 0, 8'h00));
      apply(mk(11, 0, 0, 0, 0, 1, 8'h00, 0, 8'h00));

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule